// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block collects eight interrupt request lines from peripherals and raises a single interrupt line toward a CPU. Each request line is first brought into the clock domain through a synchronizer. It is then captured into a pending-request register, either on a rising edge or as a plain high level. A mask register hides selected lines. A fixed-priority resolver compares the best unmasked pending level against the levels the CPU is already servicing. The interrupt output is raised only when that pending level is more urgent than every level in service.

When the CPU acknowledges, the winning level moves from the pending register into the in-service register. A vector byte is then driven on the outgoing data bus. It is built from a programmable base in the upper five bits and the three-bit level number in the lower bits. Software uses a small register port, gated by an active-low chip select, to set the mask, the trigger style and the vector base. Through the same port it ends service with an end-of-interrupt command and reads back the pending, in-service or mask register. The data bus is modelled as a registered value plus an output-enable flag, which is low whenever nothing is being driven.

Top module: `vic8_ctrl`

## Requirements
- R1: After a synchronous reset the pending and in-service registers are all zeros and the mask is all ones. Both `int_out` and `dbus_oe` are low.
- R2: A write with `addr`=1 loads the mask from `wdata` (bit n set hides line n). A read with `addr`=1 returns the mask.
- R3: In edge mode a low-to-high change on `irq_in[n]` sets pending bit n, and the bit stays set until that level is acknowledged. `int_out` is high by the fourth rising clock edge after the input rises.
- R4: In level mode pending bit n follows the synchronized `irq_in[n]`. Dropping the input before acknowledge clears the pending bit and lowers `int_out`.
- R5: A masked line never raises `int_out` and never hides a lower-priority unmasked request.
- R6: Priority is fixed: line 0 is the most urgent and line 7 the least. The acknowledged level is the lowest-numbered unmasked pending line.
- R7: On the first clock edge at which `inta_n` is sampled low after being high, the winner's in-service bit is set. In edge mode its pending bit is cleared. From the next cycle until the cycle after `inta_n` returns high, `dbus_oe` is high and `dbus_out` = {base[4:0], level[2:0]}. Acknowledge is honoured whatever the state of `cs_n`.
- R8: While a level is in service, pending requests of equal or lower priority keep `int_out` low. A more urgent unmasked request raises it.
- R9: Writing `addr`=0 with bit7=0, bit6=0, bits[4:2]=0 and bit5=1 is an end-of-interrupt command. It clears the lowest-numbered set in-service bit, which lets lower levels interrupt again.
- R10: An acknowledge with no eligible request returns vector {base, 3'b111} and leaves the in-service register unchanged.
- R11: With `cs_n` high, writes change nothing and reads do not assert `dbus_oe`.
- R12: Writing `addr`=0 with bit7=1 and bit5=0 sets the trigger style from bit6 (1 = level) and the vector base from bits[4:0]. An operation word (bit7=0, bit6=0, bits[4:2]=0) with bit1=1 selects what an `addr`=0 read returns: bit0=0 gives the pending register, bit0=1 the in-service register. Reset selects the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous interrupt request lines |
| cs_n | input | 1 | Active-low select for register reads and writes |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| inta_n | input | 1 | Active-low interrupt acknowledge |
| int_out | output | 1 | Interrupt request to the CPU |
| dbus_out | output | 8 | Registered outgoing data (status or vector) |
| dbus_oe | output | 1 | High while `dbus_out` is driven |

## Verification
A corrupted pending or in-service bit becomes visible at the ports within one clock. `int_out` rises or falls at the wrong time, or the next acknowledge returns a vector carrying the wrong level number. A lost in-service bit lets a lower-priority request raise `int_out` early. A stale one keeps `int_out` low after an end-of-interrupt command. Each acknowledge is followed by a read of the in-service register, so a commit into the wrong bit shows up in that status byte one cycle after the read strobe.

// File: rtl/vic8_pkg.sv
package vic8_pkg;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
  typedef enum logic {RSEL_REQ = 1'b0, RSEL_SRV = 1'b1} rsel_e;
endpackage

// File: rtl/vic8_req_sync.sv
module vic8_req_sync
  import vic8_pkg::*;
#(
  parameter int NLVL        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] irq_in,
  input  trig_e           trig,
  input  logic [NLVL-1:0] clr_vec,
  output logic [NLVL-1:0] irr
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < NLVL; g++) begin : g_lane
    logic [SYNC_STAGES-1:0] sh_q;
    logic                   prev_q;
    logic                   req_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
        req_q  <= 1'b0;
      end else begin
        sh_q   <= {sh_q[TOP-1:0], irq_in[g]};
        prev_q <= sh_q[TOP];
        if (trig == TRIG_LEVEL) begin
          req_q <= sh_q[TOP];
        end else if (sh_q[TOP] && !prev_q) begin
          req_q <= 1'b1;
        end else if (clr_vec[g]) begin
          req_q <= 1'b0;
        end
      end
    end

    assign irr[g] = req_q;
  end
endmodule

// File: rtl/vic8_prio.sv
module vic8_prio #(
  parameter int NLVL = 8,
  parameter int LW   = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] irr,
  input  logic [NLVL-1:0] mask,
  input  logic [NLVL-1:0] isr,
  output logic            beat,
  output logic [LW-1:0]   win_idx,
  output logic [NLVL-1:0] win_1h,
  output logic [NLVL-1:0] top_srv_1h
);
  logic [NLVL-1:0] pend;
  logic            pend_any;
  logic            srv_any;
  logic [LW-1:0]   srv_idx;

  assign pend = irr & ~mask;

  always_comb begin
    pend_any = 1'b0;
    win_idx  = '0;
    srv_any  = 1'b0;
    srv_idx  = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pend_any = 1'b1;
        win_idx  = LW'(i);
      end
      if (isr[i]) begin
        srv_any = 1'b1;
        srv_idx = LW'(i);
      end
    end
    beat       = pend_any && (!srv_any || (win_idx < srv_idx));
    win_1h     = NLVL'(1) << win_idx;
    top_srv_1h = srv_any ? (NLVL'(1) << srv_idx) : '0;
  end
endmodule

// File: rtl/vic8_cpu_port.sv
module vic8_cpu_port
  import vic8_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NLVL   = 8,
  parameter int BASE_W = DW - $clog2(NLVL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  output logic [NLVL-1:0]   mask_q,
  output trig_e             trig_q,
  output rsel_e             rsel_q,
  output logic [BASE_W-1:0] base_q,
  output logic              eoi_q
);
  localparam int B_CFG  = DW - 1;
  localparam int B_TRIG = DW - 2;
  localparam int B_EOI  = DW - 3;

  logic wr_hit, cfg_hit, op_hit;

  assign wr_hit  = !cs_n && !wr_n;
  assign cfg_hit = wr_hit && !addr && wdata[B_CFG] && (wdata[B_EOI:BASE_W] == '0);
  assign op_hit  = wr_hit && !addr && !wdata[B_CFG] && !wdata[B_TRIG]
                   && (wdata[B_EOI-1:2] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      trig_q <= TRIG_EDGE;
      rsel_q <= RSEL_REQ;
      base_q <= '0;
      eoi_q  <= 1'b0;
    end else begin
      eoi_q <= 1'b0;
      if (wr_hit && addr) begin
        mask_q <= wdata[NLVL-1:0];
      end
      if (cfg_hit) begin
        trig_q <= trig_e'(wdata[B_TRIG]);
        base_q <= wdata[BASE_W-1:0];
      end
      if (op_hit) begin
        eoi_q <= wdata[B_EOI];
        if (wdata[1]) begin
          rsel_q <= rsel_e'(wdata[0]);
        end
      end
    end
  end
endmodule

// File: rtl/vic8_ctrl.sv
module vic8_ctrl
  import vic8_pkg::*;
#(
  parameter int NLVL        = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] irq_in,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            addr,
  input  logic [DW-1:0]   wdata,
  input  logic            inta_n,
  output logic            int_out,
  output logic [DW-1:0]   dbus_out,
  output logic            dbus_oe
);
  localparam int LW     = $clog2(NLVL);
  localparam int BASE_W = DW - LW;

  logic [NLVL-1:0]   irr, mask_q, isr_q;
  logic [NLVL-1:0]   win_1h, top_srv_1h, clr_vec, isr_set, isr_clr;
  logic [LW-1:0]     win_idx;
  logic [BASE_W-1:0] base_q;
  logic              beat, eoi_q, inta_q, ack_start, commit;
  trig_e             trig_q;
  rsel_e             rsel_q;
  logic [DW-1:0]     rd_val;

  vic8_cpu_port #(.DW(DW), .NLVL(NLVL), .BASE_W(BASE_W)) port_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .mask_q(mask_q), .trig_q(trig_q), .rsel_q(rsel_q), .base_q(base_q), .eoi_q(eoi_q)
  );

  vic8_req_sync #(.NLVL(NLVL), .SYNC_STAGES(SYNC_STAGES)) req_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig(trig_q), .clr_vec(clr_vec), .irr(irr)
  );

  vic8_prio #(.NLVL(NLVL), .LW(LW)) prio_i (
    .irr(irr), .mask(mask_q), .isr(isr_q), .beat(beat), .win_idx(win_idx),
    .win_1h(win_1h), .top_srv_1h(top_srv_1h)
  );

  assign ack_start = !inta_n && inta_q;
  assign commit    = ack_start && beat;
  assign isr_set   = commit ? win_1h : '0;
  assign isr_clr   = eoi_q ? top_srv_1h : '0;
  assign clr_vec   = (commit && trig_q == TRIG_EDGE) ? win_1h : '0;
  assign rd_val    = addr ? DW'(mask_q) : ((rsel_q == RSEL_SRV) ? DW'(isr_q) : DW'(irr));

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q    <= '0;
      inta_q   <= 1'b1;
      int_out  <= 1'b0;
      dbus_out <= '0;
      dbus_oe  <= 1'b0;
    end else begin
      inta_q  <= inta_n;
      int_out <= beat;
      isr_q   <= (isr_q & ~isr_clr) | isr_set;
      if (ack_start) begin
        dbus_out <= {base_q, beat ? win_idx : {LW{1'b1}}};
        dbus_oe  <= 1'b1;
      end else if (!inta_n) begin
        dbus_oe  <= 1'b1;
      end else if (!cs_n && !rd_n) begin
        dbus_out <= rd_val;
        dbus_oe  <= 1'b1;
      end else begin
        dbus_oe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vic8_ctrl_chk.sv
module vic8_ctrl_chk #(
  parameter int NLVL = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            inta_n,
  input logic            cs_n,
  input logic            rd_n,
  input logic            int_out,
  input logic            dbus_oe,
  input logic [NLVL-1:0] isr,
  input logic [NLVL-1:0] irr,
  input logic [NLVL-1:0] mask
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (isr == '0 && mask == '1 && irr == '0));

  p_oe_cause_r11: assert property (@(posedge clk) disable iff (rst)
    dbus_oe |-> $past(!inta_n || (!cs_n && !rd_n)));

  p_int_pending_r5: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past((irr & ~mask) != '0));

  p_one_commit_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr & ~$past(isr)));

  p_commit_on_ack_r7: assert property (@(posedge clk) disable iff (rst)
    ((isr & ~$past(isr)) != '0) |-> $past(!inta_n));

  p_eoi_single_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0($past(isr) & ~isr));
endmodule

bind vic8_ctrl vic8_ctrl_chk #(.NLVL(NLVL)) chk_i (
  .clk(clk), .rst(rst), .inta_n(inta_n), .cs_n(cs_n), .rd_n(rd_n),
  .int_out(int_out), .dbus_oe(dbus_oe), .isr(isr_q), .irr(irr), .mask(mask_q)
);

// File: tb/vic8_ctrl_tb_top.sv
`timescale 1ns/1ps
module vic8_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq = '0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0, inta_n = 1'b1;
  logic [7:0] wdata = '0;
  logic       int_out, dbus_oe;
  logic [7:0] dbus_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  vic8_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .inta_n(inta_n), .int_out(int_out),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe)
  );

  // entry: {irq pattern, mask, expected int, expected level}
  localparam logic [19:0] TBL [0:5] = '{
    {8'h04, 8'h00, 1'b1, 3'd2},
    {8'h81, 8'h00, 1'b1, 3'd0},
    {8'h03, 8'h01, 1'b1, 3'd1},
    {8'hF0, 8'h00, 1'b1, 3'd4},
    {8'h20, 8'h20, 1'b0, 3'd7},
    {8'h80, 8'h7F, 1'b1, 3'd7}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq = '0; inta_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    d = dbus_out; oe = dbus_oe;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic ack(output logic [7:0] v, output logic oe);
    @(negedge clk);
    inta_n = 1'b0;
    @(negedge clk);
    v = dbus_out; oe = dbus_oe;
    inta_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_int();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       oe;

    // R1: reset state
    do_reset();
    @(negedge clk);
    chk("R1 int", {7'd0, int_out}, 8'h00);
    chk("R1 oe", {7'd0, dbus_oe}, 8'h00);
    rd(1'b1, v, oe);
    chk("R1 mask", v, 8'hFF);
    rd(1'b0, v, oe);
    chk("R1 irr", v, 8'h00);

    // R11: deselected write and read
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 1'b1; wdata = 8'h00;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R11 oe", {7'd0, dbus_oe}, 8'h00);
    rd_n = 1'b1;
    rd(1'b1, v, oe);
    chk("R11 mask", v, 8'hFF);

    // R2: mask write/read
    wr(1'b1, 8'h5A);
    rd(1'b1, v, oe);
    chk("R2 mask", v, 8'h5A);
    chk("R2 oe", {7'd0, oe}, 8'h01);

    // Table walk: R5, R6, R10 (ack with cs_n high covers R7 independence)
    for (int i = 0; i < 6; i++) begin
      string tg;
      logic [19:0] e;
      e  = TBL[i];
      tg = (i == 4) ? "R10" : ((i == 2) ? "R5" : "R6");
      do_reset();
      wr(1'b0, 8'h95);
      wr(1'b0, 8'h03);
      wr(1'b1, e[11:4]);
      @(negedge clk);
      irq = e[19:12];
      wait_int();
      chk({tg, " int"}, {7'd0, int_out}, {7'd0, e[3]});
      ack(v, oe);
      chk({tg, " vec"}, v, {5'h15, e[2:0]});
      chk({tg, " oe"}, {7'd0, oe}, 8'h01);
      rd(1'b0, v, oe);
      chk({tg, " isr"}, v, e[3] ? (8'h01 << e[2:0]) : 8'h00);
    end

    // R3, R7, R12: edge capture, commit, read select
    do_reset();
    wr(1'b0, 8'h95);
    wr(1'b1, 8'h00);
    @(negedge clk);
    irq = 8'h04;
    wait_int();
    chk("R3 int", {7'd0, int_out}, 8'h01);
    rd(1'b0, v, oe);
    chk("R3 irr", v, 8'h04);
    ack(v, oe);
    chk("R7 vec", v, 8'hAA);
    rd(1'b0, v, oe);
    chk("R7 irr cleared", v, 8'h00);
    wr(1'b0, 8'h03);
    rd(1'b0, v, oe);
    chk("R12 isr", v, 8'h04);

    // R8: in-service blocks lower, higher preempts
    @(negedge clk);
    irq = 8'h0C;
    wait_int();
    chk("R8 lower blocked", {7'd0, int_out}, 8'h00);
    irq = 8'h0E;
    wait_int();
    chk("R8 higher", {7'd0, int_out}, 8'h01);
    ack(v, oe);
    chk("R8 vec", v, 8'hA9);
    rd(1'b0, v, oe);
    chk("R8 isr", v, 8'h06);

    // R9: end of interrupt
    wr(1'b0, 8'h20);
    rd(1'b0, v, oe);
    chk("R9 isr first", v, 8'h04);
    wr(1'b0, 8'h20);
    rd(1'b0, v, oe);
    chk("R9 isr second", v, 8'h00);
    wait_int();
    chk("R9 lower reenabled", {7'd0, int_out}, 8'h01);
    wr(1'b0, 8'h24);
    rd(1'b0, v, oe);
    chk("R9 reserved ignored", v, 8'h00);

    // R4: level mode
    do_reset();
    wr(1'b0, 8'hD5);
    wr(1'b1, 8'h00);
    @(negedge clk);
    irq = 8'h20;
    wait_int();
    chk("R4 int", {7'd0, int_out}, 8'h01);
    rd(1'b0, v, oe);
    chk("R4 irr", v, 8'h20);
    @(negedge clk);
    irq = 8'h00;
    wait_int();
    chk("R4 int drop", {7'd0, int_out}, 8'h00);
    rd(1'b0, v, oe);
    chk("R4 irr drop", v, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule